// File: doc/BRIEF.md
# Miss Allocation and Line-State Decision Unit

This unit sits beside the tag lookup of a second-level cache. On every processor memory access it decides whether a line is brought in, whether a write miss goes straight to memory without allocation, and which coherence state the addressed line moves to. It does this by combining two cacheability attributes:

- a page-level cache-disable bit that arrives with the address;
- a per-access, active-low line-enable input from the memory bus controller.

An access is cacheable only when the page bit is clear and the line enable is asserted (low). A non-cacheable read miss leaves every piece of cache state alone. A non-cacheable write miss becomes a write-around. A read that hits a valid line is serviced as usual, whatever the page bit says.

All attributes are captured on the clock edge where the access strobe is high. The decision appears on registered outputs one clock later and lasts one cycle. The tag arrays, the data arrays and the bus sequencing use these outputs. This unit does not model any of them.

Top module: `cache_alloc_ctl`

## Requirements
- R1: While reset is held, and on the first cycle after release with no strobe, `fill_req`, `nowa_req`, `st_we` are 0 and `st_next` is 0.
- R2: Inputs are sampled on the edge where `acc_stb` is 1. The decision outputs are valid in the cycle that follows, for that one cycle only. With `acc_stb` low, `fill_req`, `nowa_req` and `st_we` are 0.
- R3: A read miss that is cacheable (`pg_cd`=0 and `ln_en_n`=0) gives `fill_req`=1 and `st_we`=1, with `st_next`=2 (Exclusive). State codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
- R4: A cacheable write miss gives `fill_req`=1 and `st_we`=1, with `st_next`=3 (Modified), and `nowa_req`=0.
- R5: A read miss with `pg_cd`=1 gives `fill_req`=0, `nowa_req`=0 and `st_we`=0, with `st_next` equal to the sampled `line_st`.
- R6: A read miss with `ln_en_n`=1 gives the same result as R5: no fill, no state write, and `st_next` equal to `line_st`.
- R7: A write miss made non-cacheable by either attribute gives `nowa_req`=1, `fill_req`=0 and `st_we`=0.
- R8: A read with `tag_hit`=1 and `line_st`≠0 gives no fill and no state write, whatever the values of `pg_cd` and `ln_en_n`. `st_next` equals `line_st`.
- R9: The line enable applies only to its own access. A cacheable miss that directly follows a non-cacheable one is allocated in full.
- R10: A write hit on an Exclusive or Modified line gives `st_we`=1 and `st_next`=3. A write hit on a Shared line gives `st_we`=0 and `st_next`=1. Neither case requests a fill or a write-around.
- R11: `tag_hit`=1 with `line_st`=0 is treated as a miss.
- R12: `fill_req` and `nowa_req` are never high together. `fill_req` always comes with `st_we`, and `nowa_req` never does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe: attributes below are valid this cycle |
| acc_wr | input | 1 | 1 for a write access, 0 for a read |
| tag_hit | input | 1 | Tag comparison matched |
| line_st | input | 2 | Current coherence state of the addressed line |
| pg_cd | input | 1 | Page-level cache-disable attribute |
| ln_en_n | input | 1 | Active-low per-access line-enable from the memory bus controller |
| fill_req | output | 1 | Request a line fill / allocation |
| nowa_req | output | 1 | Perform the write miss without allocation |
| st_we | output | 1 | Write `st_next` into the line's state |
| st_next | output | 2 | Next coherence state of the line |

## Verification
The case that is hardest to reach is an address tag that matches while its state entry is Invalid. Normal traffic rarely produces this, and it must still be treated as a miss. The bench drives `tag_hit` and `line_st` on their own, so it can force this pairing directly. It also sweeps every combination of access type, hit, state and the two attributes against its own model. To show that the line enable is not latched, the bench issues back-to-back strobes that alternate a disabled access with an enabled one.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } mesi_t;

  typedef struct packed {
    logic  fill;
    logic  nowa;
    logic  we;
    mesi_t nxt;
  } verdict_t;

  // Access may be cached only when neither attribute forbids it.
  function automatic logic may_cache(input logic page_dis, input logic line_en_n);
    return ~(page_dis | line_en_n);
  endfunction

  // A tag match only counts when the entry holds a valid state.
  function automatic logic true_hit(input logic hit, input mesi_t st);
    return hit & (st != ST_INV);
  endfunction

  function automatic verdict_t judge(input logic wr, input logic hit_v,
                                     input logic ok, input mesi_t st);
    verdict_t v;
    v.fill = 1'b0;
    v.nowa = 1'b0;
    v.we   = 1'b0;
    v.nxt  = st;
    if (hit_v) begin
      if (wr && st != ST_SHR) begin
        v.we  = 1'b1;
        v.nxt = ST_MOD;
      end
    end else if (ok) begin
      v.fill = 1'b1;
      v.we   = 1'b1;
      v.nxt  = wr ? ST_MOD : ST_EXC;
    end else if (wr) begin
      v.nowa = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/cbl_attr_gate.sv
module cbl_attr_gate
  import cbl_pkg::*;
(
  input  logic  page_dis,
  input  logic  line_en_n,
  input  logic  hit,
  input  mesi_t st,
  output logic  cacheable,
  output logic  hit_valid
);
  always_comb begin
    cacheable = may_cache(page_dis, line_en_n);
    hit_valid = true_hit(hit, st);
  end
endmodule

// File: rtl/cbl_decide.sv
module cbl_decide
  import cbl_pkg::*;
(
  input  logic     wr,
  input  logic     hit_valid,
  input  logic     cacheable,
  input  mesi_t    st,
  output verdict_t verdict
);
  always_comb verdict = judge(wr, hit_valid, cacheable, st);
endmodule

// File: rtl/cbl_out_stage.sv
module cbl_out_stage
  import cbl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stb,
  input  verdict_t verdict,
  output verdict_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (stb) begin
      q <= verdict;
    end else begin
      q <= '0;
    end
  end

  // R2: any asserted request stems from a strobe on the previous edge
  a_r2_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (q.fill || q.nowa || q.we) |-> $past(stb));

  // R2: outputs never linger into a strobe-free following cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !(q.fill || q.nowa || q.we));
endmodule

// File: rtl/cache_alloc_ctl.sv
module cache_alloc_ctl
  import cbl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_stb,
  input  logic            acc_wr,
  input  logic            tag_hit,
  input  logic [ST_W-1:0] line_st,
  input  logic            pg_cd,
  input  logic            ln_en_n,
  output logic            fill_req,
  output logic            nowa_req,
  output logic            st_we,
  output logic [ST_W-1:0] st_next
);
  mesi_t    cur_st;
  logic     ev_cacheable;
  logic     ev_hit_valid;
  verdict_t verdict_d;
  verdict_t verdict_q;

  assign cur_st = mesi_t'(line_st);

  cbl_attr_gate u_gate (
    .page_dis (pg_cd),
    .line_en_n(ln_en_n),
    .hit      (tag_hit),
    .st       (cur_st),
    .cacheable(ev_cacheable),
    .hit_valid(ev_hit_valid)
  );

  cbl_decide u_decide (
    .wr       (acc_wr),
    .hit_valid(ev_hit_valid),
    .cacheable(ev_cacheable),
    .st       (cur_st),
    .verdict  (verdict_d)
  );

  cbl_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (acc_stb),
    .verdict(verdict_d),
    .q      (verdict_q)
  );

  assign fill_req = verdict_q.fill;
  assign nowa_req = verdict_q.nowa;
  assign st_we    = verdict_q.we;
  assign st_next  = verdict_q.nxt;

  // R12: fill and write-around are exclusive
  a_r12_fill_nowa_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_req && nowa_req));

  // R12: a fill always updates state, a write-around never does
  a_r12_fill_writes_state: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> st_we);
  a_r12_nowa_no_state: assert property (@(posedge clk) disable iff (!rst_n)
    nowa_req |-> !st_we);

  // R5 R6: a disabled read miss leaves the cache untouched
  a_r5_r6_read_miss_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_wr && !ev_hit_valid && !ev_cacheable) |=> (!fill_req && !st_we));

  // R8: a valid read hit never fills regardless of the attributes
  a_r8_read_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_wr && ev_hit_valid) |=> (!fill_req && !st_we && !nowa_req));

  // R7: a blocked write miss goes around the cache
  a_r7_write_around: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_wr && !ev_hit_valid && !ev_cacheable) |=> nowa_req);

  // R3 R4: a fill always lands in an owned state
  a_r3_r4_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (st_next == ST_EXC || st_next == ST_MOD));
endmodule

// File: tb/cache_alloc_ctl_tb_top.sv
module cache_alloc_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_stb = 1'b0;
  logic       acc_wr = 1'b0;
  logic       tag_hit = 1'b0;
  logic [1:0] line_st = 2'd0;
  logic       pg_cd = 1'b0;
  logic       ln_en_n = 1'b0;
  logic       fill_req, nowa_req, st_we;
  logic [1:0] st_next;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cache_alloc_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr),
    .tag_hit(tag_hit), .line_st(line_st), .pg_cd(pg_cd), .ln_en_n(ln_en_n),
    .fill_req(fill_req), .nowa_req(nowa_req), .st_we(st_we), .st_next(st_next)
  );

  // expected {fill, nowa, we, next[1:0]}
  function automatic logic [4:0] model(input logic wr, input logic hit,
                                       input logic [1:0] st, input logic pd,
                                       input logic len_n);
    logic present;
    logic allowed;
    present = hit && (st != 2'd0);
    allowed = !pd && !len_n;
    if (present) begin
      if (!wr || st == 2'd1) return {3'b000, st};
      return 5'b00111;
    end
    if (allowed) return wr ? 5'b10111 : 5'b10110;
    if (wr) return {3'b010, st};
    return {3'b000, st};
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got fill/nowa/we/next=%b expected %b", req, got, exp);
    end
  endtask

  // one strobed access, checked one cycle later, then quiet-cycle check
  task automatic access(input string req, input logic wr, input logic hit,
                        input logic [1:0] st, input logic pd, input logic len_n,
                        input logic [4:0] exp);
    @(negedge clk);
    acc_stb = 1'b1; acc_wr = wr; tag_hit = hit; line_st = st;
    pg_cd = pd; ln_en_n = len_n;
    @(negedge clk);
    acc_stb = 1'b0;
    pg_cd = ~pd; ln_en_n = ~len_n;
    check(req, {fill_req, nowa_req, st_we, st_next}, exp);
    @(negedge clk);
    check({req, " R2 quiet"}, {fill_req, nowa_req, st_we, 2'b00}, 5'b00000);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset", {fill_req, nowa_req, st_we, st_next}, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {fill_req, nowa_req, st_we, st_next}, 5'b00000);
  endtask

  task automatic t_read_miss;
    access("R3 read miss cacheable", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 5'b10110);
    access("R5 read miss page disabled", 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 5'b00000);
    access("R6 read miss line disabled", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 5'b00000);
  endtask

  task automatic t_write_miss;
    access("R4 write miss cacheable", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 5'b10111);
    access("R7 write miss page disabled", 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 5'b01000);
    access("R7 write miss line disabled", 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 5'b01000);
  endtask

  task automatic t_read_hit;
    access("R8 read hit E page disabled", 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 5'b00010);
    access("R8 read hit S both disabled", 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 5'b00001);
    access("R8 read hit M", 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 5'b00011);
  endtask

  task automatic t_write_hit;
    access("R10 write hit E", 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 5'b00111);
    access("R10 write hit S", 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 5'b00001);
    access("R10 write hit M disabled", 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 5'b00111);
  endtask

  task automatic t_invalid_hit;
    access("R11 hit on invalid read", 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'b10110);
    access("R11 hit on invalid write blocked", 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 5'b01000);
  endtask

  task automatic t_no_latch;
    // back-to-back strobes: disabled then enabled
    @(negedge clk);
    acc_stb = 1'b1; acc_wr = 1'b0; tag_hit = 1'b0; line_st = 2'd0;
    pg_cd = 1'b0; ln_en_n = 1'b1;
    @(negedge clk);
    check("R9 first disabled", {fill_req, nowa_req, st_we, st_next}, 5'b00000);
    ln_en_n = 1'b0;
    @(negedge clk);
    check("R9 next enabled", {fill_req, nowa_req, st_we, st_next}, 5'b10110);
    acc_wr = 1'b1; ln_en_n = 1'b1;
    @(negedge clk);
    check("R9 disabled write", {fill_req, nowa_req, st_we, st_next}, 5'b01000);
    ln_en_n = 1'b0;
    @(negedge clk);
    acc_stb = 1'b0;
    check("R9 enabled write", {fill_req, nowa_req, st_we, st_next}, 5'b10111);
    @(negedge clk);
    check("R2 idle after burst", {fill_req, nowa_req, st_we, 2'b00}, 5'b00000);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 64; k++) begin
      logic [5:0] c;
      c = 6'(k);
      access("R12 sweep", c[5], c[4], c[3:2], c[1], c[0],
             model(c[5], c[4], c[3:2], c[1], c[0]));
      n_chk++;
      if ((fill_req && nowa_req) || (fill_req && !st_we)) begin
        n_bad++;
        $display("FAIL R12: fill=%b nowa=%b we=%b expected exclusive", fill_req, nowa_req, st_we);
      end
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_miss();
    t_write_miss();
    t_read_hit();
    t_write_hit();
    t_invalid_hit();
    t_no_latch();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule